// File: doc/BRIEF.md
# Microstep step/direction translator

This block turns a stream of step pulses and a direction level into per-winding current commands for a two-phase bipolar stepper motor. It keeps a 5-bit position index into a 32-point electrical cycle, with neighbouring points 11.25 degrees apart. For each winding it drives an unsigned 8-bit magnitude code and a polarity bit. It also picks a current-decay mode for each winding after every move. Winding A follows the cosine of the electrical angle and winding B follows the sine.

The step, direction and resolution pins may be asynchronous to the clock. They all pass through the same synchronizer, so the direction and resolution used for a move are the values present when that step edge was captured. Only a rising step edge moves the index. Several conditions send the index back to the 45-degree home point and force both magnitudes to zero: the active-low reset, sleep, and the undervoltage flag. The output-enable and thermal-fault inputs never touch the translator; they only gate the `drive_on` flag handed to the power stage. All pins are plain level signals, because the block carries no data stream that would need a valid/ready handshake.

Top module: `microstep_xlate`

## Requirements
- R1: A step edge moves the index by 8, 4, 2 or 1 points. The resolution is encoded as {res_b,res_a}: 00 is full step (8), res_a=1 with res_b=0 is half step (4), res_a=0 with res_b=1 is quarter step (2), and 11 is eighth step (1).
- R2: With dir_in high the index increases, and with dir_in low it decreases. The index wraps modulo 32 in both directions, including when it is off the coarse grid.
- R3: At index p, winding B carries |sin(p*11.25 deg)| and winding A carries |cos(p*11.25 deg)|, each scaled to 255 and rounded. The resulting codes are 0, 50, 98, 142, 180, 212, 236, 250 and 255. Polarity is 1 when the current is non-negative: pol_b is 1 for p in 0..16, and pol_a is 1 for p in 0..8 or 24..31. Whenever one winding reads 0, the other reads 255.
- R4: The index starts at home (p = 4, both magnitudes 180, both polarities 1) and returns there after a reset, a power-up, a wake from sleep or the clearing of undervoltage. At home both decay outputs read mixed (2'b10).
- R5: While rst_n is low, both magnitudes are 0, drive_on is 0, and step edges are ignored.
- R6: While sleep_n is low or uv_flag is high, both magnitudes read 0 at once. The index is held at home and step edges are ignored.
- R7: After a move, a winding whose magnitude fell takes its decay from decay_pref: 00 gives slow, 01 gives fast, and 10 or 11 give mixed. A winding whose magnitude rose or stayed equal takes slow. The output codes are slow 2'b00, fast 2'b01 and mixed 2'b10, and 2'b11 never appears.
- R8: Changing dir_in, res_a or res_b without a step edge changes no output.
- R9: A rising edge on step_in updates the outputs on the third rising clock edge after it. A high or falling level on step_in never moves the index.
- R10: drive_on is 1 only when rst_n and sleep_n are high and uv_flag, en_n and therm_flt are low. en_n and therm_flt do not affect the index, the magnitudes or the decay modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; translator to home, outputs off |
| step_in | input | 1 | Step pulse, asynchronous, rising edge active |
| dir_in | input | 1 | Direction: 1 forward, 0 reverse |
| res_a | input | 1 | Resolution select, first bit |
| res_b | input | 1 | Resolution select, second bit |
| sleep_n | input | 1 | Active-low sleep |
| uv_flag | input | 1 | Undervoltage present |
| decay_pref | input | 2 | Decay used when a magnitude falls |
| en_n | input | 1 | Active-low output enable, pass-through only |
| therm_flt | input | 1 | Thermal fault, pass-through only |
| mag_a | output | 8 | Winding A (cosine) magnitude code |
| pol_a | output | 1 | Winding A polarity, 1 = positive |
| decay_a | output | 2 | Winding A decay mode |
| mag_b | output | 8 | Winding B (sine) magnitude code |
| pol_b | output | 1 | Winding B polarity, 1 = positive |
| decay_b | output | 2 | Winding B decay mode |
| drive_on | output | 1 | Power stage may drive |

## Verification
The step edge runs through two synchronizer stages and one edge register before it reaches the index. Magnitude, polarity and decay therefore change on the third rising edge after step_in rises. The bench drives inputs on falling edges and samples one falling edge after that third edge; it also samples once after only two edges, to show that nothing has moved early. The reset, sleep and undervoltage inputs force the magnitudes to zero without a register, and drive_on is purely combinational, so both are checked on the falling edge right after the input changes. The return to home is registered on the next rising edge, so it is checked one falling edge after the condition clears.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  localparam int POS_W    = 5;
  localparam int POS_N    = 1 << POS_W;
  localparam int QSTEPS   = POS_N / 4;
  localparam int MAG_W    = 8;
  localparam int HOME_POS = QSTEPS / 2;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10
  } decay_t;

  // sine magnitude for 0..8 eighths of a quarter wave, full scale 255
  function automatic logic [MAG_W-1:0] quarter_mag(input logic [3:0] k);
    case (k)
      4'd0:    return 8'd0;
      4'd1:    return 8'd50;
      4'd2:    return 8'd98;
      4'd3:    return 8'd142;
      4'd4:    return 8'd180;
      4'd5:    return 8'd212;
      4'd6:    return 8'd236;
      4'd7:    return 8'd250;
      default: return 8'd255;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] wave_mag(input logic [POS_W-1:0] p);
    int pi;
    logic [3:0] k;
    pi = int'(p);
    if (pi <= QSTEPS)          k = 4'(pi);
    else if (pi <= 2*QSTEPS)   k = 4'(2*QSTEPS - pi);
    else if (pi <= 3*QSTEPS)   k = 4'(pi - 2*QSTEPS);
    else                       k = 4'(POS_N - pi);
    return quarter_mag(k);
  endfunction

  function automatic logic wave_pos(input logic [POS_W-1:0] p);
    return int'(p) <= 2*QSTEPS;
  endfunction

  function automatic decay_t pick_decay(input logic [1:0] pref);
    case (pref)
      2'b00:   return DK_SLOW;
      2'b01:   return DK_FAST;
      default: return DK_MIXED;
    endcase
  endfunction
endpackage

// File: rtl/mstep_sync.sv
module mstep_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:1] ctl,
  output logic         rise
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic                     tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
      tail <= 1'b0;
    end else begin
      pipe <= {pipe[STAGES-2:0], d};
      tail <= pipe[STAGES-1][0];
    end
  end

  assign ctl  = pipe[STAGES-1][W-1:1];
  assign rise = pipe[STAGES-1][0] & ~tail;
endmodule

// File: rtl/mstep_index.sv
module mstep_index
  import mstep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             adv,
  input  logic             dir,
  input  logic [1:0]       res,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt,
  output logic             moved
);
  localparam logic [POS_W-1:0] FULL_INC = POS_W'(QSTEPS);
  localparam logic [POS_W-1:0] HOME     = POS_W'(HOME_POS);

  logic [POS_W-1:0] step_sz;

  assign step_sz = FULL_INC >> res;
  assign pos_nxt = dir ? pos + step_sz : pos - step_sz;
  assign moved   = adv & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= HOME;
    else if (hold)  pos <= HOME;
    else if (adv)   pos <= pos_nxt;
  end
endmodule

// File: rtl/mstep_winding.sv
module mstep_winding
  import mstep_pkg::*;
#(
  parameter int OFS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             off,
  input  logic             moved,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] pos_nxt,
  input  logic [1:0]       pref,
  output logic [MAG_W-1:0] mag,
  output logic             pol,
  output logic [1:0]       decay
);
  localparam logic [POS_W-1:0] OFS_V = POS_W'(OFS);

  logic [POS_W-1:0] wpos, wnxt;
  logic [MAG_W-1:0] cur_mag, new_mag;
  decay_t           decay_q;

  assign wpos    = pos + OFS_V;
  assign wnxt    = pos_nxt + OFS_V;
  assign cur_mag = wave_mag(wpos);
  assign new_mag = wave_mag(wnxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      decay_q <= DK_MIXED;
    else if (hold)   decay_q <= DK_MIXED;
    else if (moved)  decay_q <= (new_mag < cur_mag) ? pick_decay(pref) : DK_SLOW;
  end

  assign mag   = off ? '0 : cur_mag;
  assign pol   = off ? 1'b1 : wave_pos(wpos);
  assign decay = decay_q;
endmodule

// File: rtl/microstep_xlate.sv
module microstep_xlate
  import mstep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic             res_a,
  input  logic             res_b,
  input  logic             sleep_n,
  input  logic             uv_flag,
  input  logic [1:0]       decay_pref,
  input  logic             en_n,
  input  logic             therm_flt,
  output logic [MAG_W-1:0] mag_a,
  output logic             pol_a,
  output logic [1:0]       decay_a,
  output logic [MAG_W-1:0] mag_b,
  output logic             pol_b,
  output logic [1:0]       decay_b,
  output logic             drive_on
);
  localparam int NWIND = 2;

  logic [3:1]       ctl;
  logic             step_rise;
  logic             hold, off, moved;
  logic [POS_W-1:0] pos, pos_nxt;

  logic [NWIND-1:0][MAG_W-1:0] w_mag;
  logic [NWIND-1:0]            w_pol;
  logic [NWIND-1:0][1:0]       w_dk;

  // bit 0 is the step level; direction and resolution travel alongside it
  mstep_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({res_b, res_a, dir_in, step_in}),
    .ctl  (ctl),
    .rise (step_rise)
  );

  assign hold = uv_flag | ~sleep_n;
  assign off  = ~rst_n | hold;

  mstep_index u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .adv    (step_rise),
    .dir    (ctl[1]),
    .res    (ctl[3:2]),
    .pos    (pos),
    .pos_nxt(pos_nxt),
    .moved  (moved)
  );

  // winding 0 leads by a quarter cycle (cosine), winding 1 is the sine
  for (genvar w = 0; w < NWIND; w++) begin : g_wind
    mstep_winding #(.OFS(w == 0 ? QSTEPS : 0)) u_wind (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .off    (off),
      .moved  (moved),
      .pos    (pos),
      .pos_nxt(pos_nxt),
      .pref   (decay_pref),
      .mag    (w_mag[w]),
      .pol    (w_pol[w]),
      .decay  (w_dk[w])
    );
  end

  assign mag_a   = w_mag[0];
  assign pol_a   = w_pol[0];
  assign decay_a = w_dk[0];
  assign mag_b   = w_mag[1];
  assign pol_b   = w_pol[1];
  assign decay_b = w_dk[1];

  assign drive_on = ~off & ~en_n & ~therm_flt;
endmodule

// File: rtl/microstep_xlate_chk.sv
module microstep_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_n,
  input logic       uv_flag,
  input logic       en_n,
  input logic       therm_flt,
  input logic       step_rise,
  input logic [7:0] mag_a,
  input logic [7:0] mag_b,
  input logic       pol_a,
  input logic       pol_b,
  input logic [1:0] decay_a,
  input logic [1:0] decay_b,
  input logic       drive_on
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag || !sleep_n) |-> (mag_a == 8'd0 && mag_b == 8'd0));

  assert_home_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uv_flag || !sleep_n) && !uv_flag && sleep_n) |->
      (mag_a == 8'd180 && mag_b == 8'd180 && pol_a && pol_b &&
       decay_a == 2'b10 && decay_b == 2'b10));

  assert_no_edge_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(step_rise) && !$past(uv_flag || !sleep_n) && !uv_flag && sleep_n) |->
      ($stable(mag_a) && $stable(mag_b) && $stable(pol_a) && $stable(pol_b) &&
       $stable(decay_a) && $stable(decay_b)));

  assert_decay_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decay_a != 2'b11 && decay_b != 2'b11));

  assert_quad_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_flag && sleep_n && mag_a == 8'd0) |-> (mag_b == 8'd255));

  assert_quad_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_flag && sleep_n && mag_b == 8'd0) |-> (mag_a == 8'd255));

  assert_drive_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n || therm_flt) |-> !drive_on);
endmodule

bind microstep_xlate microstep_xlate_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep_n  (sleep_n),
  .uv_flag  (uv_flag),
  .en_n     (en_n),
  .therm_flt(therm_flt),
  .step_rise(step_rise),
  .mag_a    (mag_a),
  .mag_b    (mag_b),
  .pol_a    (pol_a),
  .pol_b    (pol_b),
  .decay_a  (decay_a),
  .decay_b  (decay_b),
  .drive_on (drive_on)
);

// File: tb/microstep_xlate_bench.sv
`timescale 1ns/1ps
module microstep_xlate_bench;
  logic clk = 1'b0;
  logic rst_n, step_in, dir_in, res_a, res_b, sleep_n, uv_flag, en_n, therm_flt;
  logic [1:0] decay_pref;
  logic [7:0] mag_a, mag_b;
  logic pol_a, pol_b, drive_on;
  logic [1:0] decay_a, decay_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected state of the bench model
  int m_idx = 4;
  int m_da = 2;
  int m_db = 2;

  always #2.5 clk = ~clk;

  microstep_xlate u_microstep_xlate (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
    .res_a(res_a), .res_b(res_b), .sleep_n(sleep_n), .uv_flag(uv_flag),
    .decay_pref(decay_pref), .en_n(en_n), .therm_flt(therm_flt),
    .mag_a(mag_a), .pol_a(pol_a), .decay_a(decay_a),
    .mag_b(mag_b), .pol_b(pol_b), .decay_b(decay_b), .drive_on(drive_on)
  );

  // {dir, {res_b,res_a}, decay_pref, expected index}
  localparam logic [9:0] VEC [14] = '{
    {1'b1, 2'b00, 2'b00, 5'd12},
    {1'b1, 2'b01, 2'b01, 5'd16},
    {1'b1, 2'b10, 2'b10, 5'd18},
    {1'b1, 2'b11, 2'b00, 5'd19},
    {1'b0, 2'b11, 2'b01, 5'd18},
    {1'b0, 2'b00, 2'b10, 5'd10},
    {1'b0, 2'b00, 2'b01, 5'd2},
    {1'b0, 2'b01, 2'b11, 5'd30},
    {1'b1, 2'b10, 2'b01, 5'd0},
    {1'b1, 2'b00, 2'b10, 5'd8},
    {1'b1, 2'b00, 2'b01, 5'd16},
    {1'b1, 2'b00, 2'b00, 5'd24},
    {1'b1, 2'b00, 2'b10, 5'd0},
    {1'b1, 2'b11, 2'b01, 5'd1}
  };

  function automatic int exp_mag(int p);
    real s;
    s = $sin(2.0 * 3.14159265358979 * p / 32.0);
    if (s < 0.0) s = -s;
    return $rtoi(s * 255.0 + 0.5);
  endfunction

  function automatic int exp_pol(int p);
    return (p <= 16) ? 1 : 0;
  endfunction

  function automatic int map_pref(int pref);
    return (pref == 0) ? 0 : (pref == 1) ? 1 : 2;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_move(input int nidx, input int pref);
    int pa_o, pa_n;
    pa_o = (m_idx + 8) % 32;
    pa_n = (nidx + 8) % 32;
    m_da = (exp_mag(pa_n) < exp_mag(pa_o)) ? map_pref(pref) : 0;
    m_db = (exp_mag(nidx) < exp_mag(m_idx)) ? map_pref(pref) : 0;
    m_idx = nidx;
  endtask

  task automatic model_home();
    m_idx = 4; m_da = 2; m_db = 2;
  endtask

  task automatic check_state(input string req);
    int pa;
    pa = (m_idx + 8) % 32;
    chk(req, "mag_a", int'(mag_a), exp_mag(pa));
    chk(req, "pol_a", int'(pol_a), exp_pol(pa));
    chk(req, "mag_b", int'(mag_b), exp_mag(m_idx));
    chk(req, "pol_b", int'(pol_b), exp_pol(m_idx));
    chk(req, "decay_a", int'(decay_a), m_da);
    chk(req, "decay_b", int'(decay_b), m_db);
  endtask

  task automatic check_off(input string req);
    chk(req, "mag_a off", int'(mag_a), 0);
    chk(req, "mag_b off", int'(mag_b), 0);
    chk(req, "drive_on off", int'(drive_on), 0);
  endtask

  // raise step with direction and resolution; return at the sample point
  task automatic step_up(input logic d, input logic [1:0] r);
    @(negedge clk);
    dir_in = d; res_a = r[0]; res_b = r[1]; step_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step_down();
    step_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_in = 1'b0; dir_in = 1'b1; res_a = 1'b0; res_b = 1'b0;
    sleep_n = 1'b1; uv_flag = 1'b0; en_n = 1'b0; therm_flt = 1'b0; decay_pref = 2'b00;
    repeat (3) @(negedge clk);
    // R5: outputs off during reset, decays mixed
    check_off("R5");
    chk("R4", "decay_a reset", int'(decay_a), 2);
    chk("R4", "decay_b reset", int'(decay_b), 2);
    // R5: step edge during reset ignored
    step_in = 1'b1; repeat (4) @(negedge clk);
    step_in = 1'b0; repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_home();
    check_state("R4");
    chk("R10", "drive_on live", int'(drive_on), 1);

    // table walk: R1 R2 R3 R7, and R9 for the falling edge
    for (int i = 0; i < 14; i++) begin
      decay_pref = VEC[i][6:5];
      step_up(VEC[i][9], VEC[i][8:7]);
      model_move(int'(VEC[i][4:0]), int'(VEC[i][6:5]));
      check_state("R1");
      step_down();
      check_state("R9");
    end

    // R9: latency is three rising edges
    decay_pref = 2'b00;
    @(negedge clk);
    dir_in = 1'b1; res_a = 1'b0; res_b = 1'b0; step_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_state("R9");
    @(posedge clk);
    @(negedge clk);
    model_move(9, 0);
    check_state("R9");
    step_down();

    // R8: resolution and direction changes without a step do nothing
    dir_in = 1'b0; res_a = 1'b1; res_b = 1'b1;
    repeat (6) @(negedge clk);
    check_state("R8");
    step_up(1'b0, 2'b11);
    model_move(8, 0);
    check_state("R8");
    step_down();

    // R10: enable and thermal fault do not gate the translator
    en_n = 1'b1;
    @(negedge clk);
    chk("R10", "drive_on en_n", int'(drive_on), 0);
    step_up(1'b1, 2'b01);
    model_move(12, 0);
    check_state("R10");
    step_down();
    en_n = 1'b0; therm_flt = 1'b1;
    @(negedge clk);
    chk("R10", "drive_on therm", int'(drive_on), 0);
    check_state("R10");
    therm_flt = 1'b0;
    @(negedge clk);
    chk("R10", "drive_on clear", int'(drive_on), 1);

    // R6: undervoltage forces off and home, steps ignored
    uv_flag = 1'b1;
    @(negedge clk);
    check_off("R6");
    step_up(1'b1, 2'b00);
    check_off("R6");
    step_down();
    uv_flag = 1'b0;
    @(negedge clk);
    model_home();
    check_state("R6");

    // R6: sleep and wake
    step_up(1'b1, 2'b00);
    model_move(12, 0);
    check_state("R2");
    step_down();
    sleep_n = 1'b0;
    @(negedge clk);
    check_off("R6");
    sleep_n = 1'b1;
    @(negedge clk);
    model_home();
    check_state("R4");

    // R5: reset in mid run returns home
    step_up(1'b0, 2'b00);
    model_move(28, 0);
    check_state("R2");
    step_down();
    rst_n = 1'b0;
    @(negedge clk);
    check_off("R5");
    rst_n = 1'b1;
    @(negedge clk);
    model_home();
    check_state("R4");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule